// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block decides, once per timeslot, which inputs of an N-by-N crossbar are connected to which outputs. Each input holds one virtual queue per output. The occupancy of those queues arrives as a request matrix. A start pulse samples that matrix. The block then runs a fixed number of matching iterations, one per clock. Each iteration has three phases. First, every unmatched input asks for every unmatched output it has traffic for. Next, every output grants one asking input in round-robin order. Finally, every input accepts one of its grants in round-robin order. Pairs made in one iteration are kept. Later iterations only try to match the ports that are still free.

Each output holds a grant pointer and each input holds an accept pointer. A pointer moves only when a grant is accepted in the first iteration, and it moves to one past the port just served. Because of this rule, a port that keeps requesting cannot be passed over forever. When the last iteration completes, a one-cycle done strobe is raised. The per-input match flags and output indices stay unchanged until the next accepted start.

Top module: `crossbar_rr_matcher`

## Requirements
- R1: While reset is held and just after it is released, all match flags are 0 and done is 0.
- R2: No two inputs with a set match flag ever carry the same output index.
- R3: Every reported match (input i, output j) has bit i*N+j set in the request matrix sampled at start.
- R4: The start edge is followed by exactly ITERS clock edges, after which done is high for a single cycle. The match outputs then hold their values until the next accepted start.
- R5: A start pulse that arrives while an iteration sequence is running is ignored. Changes to the request matrix after the start edge do not affect the result.
- R6: When ITERS is at least N, the result is maximal at done. No request bit may have both its input and its output left unmatched.
- R7: After reset, all pointers are 0. With N=4 and ITERS=3, an all-ones request gives input0→0, input1→1, input2→2, and input3 unmatched. Repeating the same request in the next timeslot gives input0→1, input1→0, input2→2 and input3→3.
- R8: Suppose all inputs request only output 0 in successive timeslots. Then output 0 serves the inputs in rising cyclic order, so each input is served exactly once in any N consecutive timeslots.
- R9: A non-zero request matrix always produces at least one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts one timeslot's matching when the block is idle |
| req_i | input | N*N | Request matrix; bit i*N+j means input i has traffic for output j |
| match_vld_o | output | N | Bit i set when input i is matched |
| match_port_o | output | N*$clog2(N) | Output index of input i in bits [i*W +: W] |
| done_o | output | 1 | One-cycle strobe when the matching is complete |

## Verification
The bound checker checks the following on every cycle:
- The one-input-per-output rule.
- That matches are taken only from the request matrix sampled at start.
- The timing and single-cycle width of the done strobe.
- That results are held while the block is idle.
- Progress on any non-empty request.
- Maximality, in configurations with at least N iterations.

Some behaviours cannot be seen by looking at one cycle. These are:
- The exact pairings that come out of the pointer update rule.
- The cyclic service order under persistent contention.
- That a start arriving during a run is discarded.

Only the bench's scenarios show these, together with a sweep of several thousand request matrices run on a 3-iteration and a 4-iteration copy side by side.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    // Cyclic successor of a port index in a ring of n ports.
    function automatic int rrm_wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/rrm_rr_pick.sv
// Picks the first set candidate at or after ptr, going cyclically.
module rrm_rr_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] cand,
    input  logic [W-1:0] ptr,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (int'(ptr) + k) % N;
            if (!any && cand[p]) begin
                any = 1'b1;
                idx = W'(p);
            end
        end
    end
endmodule

// File: rtl/rrm_grant_stage.sv
// Every free output grants one free requesting input.
module rrm_grant_stage #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0][N-1:0] req,      // req[i][j]
    input  logic [N-1:0]        in_busy,
    input  logic [N-1:0]        out_busy,
    input  logic [N-1:0][W-1:0] gptr,
    output logic [N-1:0][N-1:0] gnt       // gnt[j][i]
);
    logic [N-1:0][N-1:0] col;
    logic [N-1:0]        g_any;
    logic [N-1:0][W-1:0] g_idx;

    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col[j][i] = req[i][j] & ~in_busy[i] & ~out_busy[j];
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        rrm_rr_pick #(.N(N), .W(W)) u_pick (
            .cand (col[j]),
            .ptr  (gptr[j]),
            .any  (g_any[j]),
            .idx  (g_idx[j])
        );
        assign gnt[j] = g_any[j] ? ({{(N-1){1'b0}}, 1'b1} << g_idx[j]) : '0;
    end
endmodule

// File: rtl/rrm_accept_stage.sv
// Every input accepts one of the grants it received.
module rrm_accept_stage #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0][N-1:0] gnt,      // gnt[j][i]
    input  logic [N-1:0][W-1:0] aptr,
    output logic [N-1:0]        acc_vld,
    output logic [N-1:0][W-1:0] acc_port
);
    logic [N-1:0][N-1:0] row;

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                row[i][j] = gnt[j][i];
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        rrm_rr_pick #(.N(N), .W(W)) u_pick (
            .cand (row[i]),
            .ptr  (aptr[i]),
            .any  (acc_vld[i]),
            .idx  (acc_port[i])
        );
    end
endmodule

// File: rtl/crossbar_rr_matcher.sv
module crossbar_rr_matcher #(
    parameter int N     = 4,
    parameter int ITERS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [N*N-1:0]            req_i,
    output logic [N-1:0]              match_vld_o,
    output logic [N*$clog2(N)-1:0]    match_port_o,
    output logic                      done_o
);
    import rrm_pkg::*;

    localparam int W  = $clog2(N);
    localparam int CW = $clog2(ITERS + 1);

    typedef struct packed {
        logic                busy;
        logic [CW-1:0]       iter;
        logic [N-1:0][N-1:0] req;
        logic [N-1:0]        in_vld;
        logic [N-1:0][W-1:0] in_port;
        logic [N-1:0]        out_used;
        logic [N-1:0][W-1:0] gptr;
        logic [N-1:0][W-1:0] aptr;
        logic                done;
    } state_t;

    state_t s_q, s_d;

    logic [N-1:0][N-1:0] gnt;
    logic [N-1:0]        acc_vld;
    logic [N-1:0][W-1:0] acc_port;

    rrm_grant_stage #(.N(N), .W(W)) u_grant (
        .req      (s_q.req),
        .in_busy  (s_q.in_vld),
        .out_busy (s_q.out_used),
        .gptr     (s_q.gptr),
        .gnt      (gnt)
    );

    rrm_accept_stage #(.N(N), .W(W)) u_accept (
        .gnt      (gnt),
        .aptr     (s_q.aptr),
        .acc_vld  (acc_vld),
        .acc_port (acc_port)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy     = 1'b1;
                s_d.iter     = '0;
                s_d.req      = req_i;
                s_d.in_vld   = '0;
                s_d.in_port  = '0;
                s_d.out_used = '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (acc_vld[i]) begin
                    s_d.in_vld[i]            = 1'b1;
                    s_d.in_port[i]           = acc_port[i];
                    s_d.out_used[acc_port[i]] = 1'b1;
                    if (s_q.iter == '0) begin
                        s_d.aptr[i]           = W'(rrm_wrap_inc(int'(acc_port[i]), N));
                        s_d.gptr[acc_port[i]] = W'(rrm_wrap_inc(i, N));
                    end
                end
            end
            s_d.iter = s_q.iter + 1'b1;
            if (s_q.iter == CW'(ITERS - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign match_vld_o  = s_q.in_vld;
    assign match_port_o = s_q.in_port;
    assign done_o       = s_q.done;

endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
    parameter int N     = 4,
    parameter int ITERS = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic [N*N-1:0]         req_i,
    input logic [N-1:0]           match_vld_o,
    input logic [N*$clog2(N)-1:0] match_port_o,
    input logic                   done_o
);
    localparam int W  = $clog2(N);
    localparam int CW = $clog2(ITERS + 1);

    logic           act_q;
    logic [CW-1:0]  cnt_q;
    logic           exp_done_q;
    logic [N*N-1:0] req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            cnt_q      <= '0;
            exp_done_q <= 1'b0;
            req_q      <= '0;
        end else begin
            exp_done_q <= 1'b0;
            if (!act_q && start_i) begin
                act_q <= 1'b1;
                cnt_q <= '0;
                req_q <= req_i;
            end else if (act_q) begin
                if (cnt_q == CW'(ITERS - 1)) begin
                    act_q      <= 1'b0;
                    exp_done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    logic conflict, unreq, not_max, any_req, any_match;
    always_comb begin
        logic [N-1:0] used;
        conflict  = 1'b0;
        unreq     = 1'b0;
        not_max   = 1'b0;
        used      = '0;
        any_req   = |req_q;
        any_match = |match_vld_o;
        for (int i = 0; i < N; i++) begin
            if (match_vld_o[i]) begin
                if (used[match_port_o[i*W +: W]]) conflict = 1'b1;
                used[match_port_o[i*W +: W]] = 1'b1;
                if (!req_q[i*N + int'(match_port_o[i*W +: W])]) unreq = 1'b1;
            end
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (req_q[i*N+j] && !match_vld_o[i] && !used[j]) not_max = 1'b1;
    end

    AST_ONE_INPUT_PER_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) !conflict);                 // R2
    AST_ONLY_REQUESTED:       assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !unreq);         // R3
    AST_DONE_SCHEDULE:        assert property (@(posedge clk) disable iff (!rst_n) done_o == exp_done_q);      // R4
    AST_DONE_SINGLE:          assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);        // R4
    AST_HOLD_IDLE:            assert property (@(posedge clk) disable iff (!rst_n)
                                  (!act_q && !start_i) |=> ($stable(match_vld_o) && $stable(match_port_o))); // R5
    AST_PROGRESS:             assert property (@(posedge clk) disable iff (!rst_n)
                                  (done_o && any_req) |-> any_match);                                          // R9

    if (ITERS >= N) begin : g_max
        AST_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !not_max);                // R6
    end

endmodule

bind crossbar_rr_matcher rrm_checker #(.N(N), .ITERS(ITERS)) u_rrm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .req_i        (req_i),
    .match_vld_o  (match_vld_o),
    .match_port_o (match_port_o),
    .done_o       (done_o)
);

// File: tb/crossbar_rr_matcher_bench.sv
`timescale 1ns/1ps
module crossbar_rr_matcher_bench;
    localparam int N = 4;
    localparam int W = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*N-1:0] req = '0;
    logic [N-1:0]   vld_m, vld_f;
    logic [N*W-1:0] port_m, port_f;
    logic           done_m, done_f;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crossbar_rr_matcher #(.N(N), .ITERS(3)) u_crossbar_rr_matcher (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(req),
        .match_vld_o(vld_m), .match_port_o(port_m), .done_o(done_m));

    crossbar_rr_matcher #(.N(N), .ITERS(N)) u_crossbar_rr_matcher_full (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(req),
        .match_vld_o(vld_f), .match_port_o(port_f), .done_o(done_f));

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic bit legal(input logic [N-1:0] v, input logic [N*W-1:0] p);
        logic [N-1:0] used = '0;
        for (int i = 0; i < N; i++)
            if (v[i]) begin
                if (used[p[i*W +: W]]) return 1'b0;
                used[p[i*W +: W]] = 1'b1;
            end
        return 1'b1;
    endfunction

    function automatic bit requested(input logic [N*N-1:0] r, input logic [N-1:0] v, input logic [N*W-1:0] p);
        for (int i = 0; i < N; i++)
            if (v[i] && !r[i*N + int'(p[i*W +: W])]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit maximal(input logic [N*N-1:0] r, input logic [N-1:0] v, input logic [N*W-1:0] p);
        logic [N-1:0] used = '0;
        for (int i = 0; i < N; i++) if (v[i]) used[p[i*W +: W]] = 1'b1;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (r[i*N+j] && !v[i] && !used[j]) return 1'b0;
        return 1'b1;
    endfunction

    // One timeslot on both copies; returns cycles from start edge to done.
    task automatic slot(input logic [N*N-1:0] r, output int cm, output int cf);
        @(negedge clk);
        req = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cm = -1; cf = -1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (done_m && cm < 0) cm = k;
            if (done_f && cf < 0) cf = k;
            if (cm >= 0 && cf >= 0) break;
        end
    endtask

    initial begin
        int cm, cf;
        int served [8];
        logic [N-1:0]   v0;
        logic [N*W-1:0] p0;
        logic [15:0]    x;

        repeat (3) @(negedge clk);
        check(vld_m == '0 && vld_f == '0, "R1", "match flags in reset", int'(vld_m), 0);
        check(!done_m && !done_f, "R1", "done in reset", int'(done_m), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(vld_m == '0 && !done_m, "R1", "match flags after reset", int'(vld_m), 0);

        // R7: first all-ones timeslot from zero pointers
        slot('1, cm, cf);
        check(cm == 3, "R4", "done latency ITERS=3", cm, 3);
        check(cf == 4, "R4", "done latency ITERS=4", cf, 4);
        check(vld_m == 4'b0111, "R7", "flags slot 1", int'(vld_m), 7);
        check(port_m[5:0] == 6'b10_01_00, "R7", "ports slot 1", int'(port_m[5:0]), 6'b10_01_00);
        check(maximal('1, vld_f, port_f), "R6", "full copy maximal slot 1", 0, 1);
        // R7: second identical timeslot
        slot('1, cm, cf);
        check(vld_m == 4'b1111, "R7", "flags slot 2", int'(vld_m), 15);
        check(port_m == 8'b11_10_00_01, "R7", "ports slot 2", int'(port_m), 8'b11_10_00_01);

        // R4: results held while idle, no spurious done
        v0 = vld_m; p0 = port_m;
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done_m) extra = 1'b1;
            end
            check(!extra, "R4", "no done while idle", int'(extra), 0);
        end
        check(vld_m == v0 && port_m == p0, "R4", "ports held while idle", int'(port_m), int'(p0));

        // R5: start during a run and request changes are ignored
        @(negedge clk);
        req = 16'h0200; start = 1'b1;          // input 2 -> output 1
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        req = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done_m, "R5", "done on schedule despite extra start", int'(done_m), 1);
        check(vld_m == 4'b0100 && port_m[5:4] == 2'd1, "R5", "result from sampled request", int'(vld_m), 4);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done_m) extra = 1'b1;
            end
            check(!extra, "R5", "ignored start gives no second done", int'(extra), 0);
        end

        // R8: all inputs contend for output 0
        for (int t = 0; t < 8; t++) begin
            slot(16'h1111, cm, cf);
            check($countones(vld_m) == 1, "R8", "one match per slot", $countones(vld_m), 1);
            served[t] = 0;
            for (int i = 0; i < N; i++) if (vld_m[i]) served[t] = i;
        end
        for (int t = 0; t < 7; t++)
            check(served[t+1] == (served[t] + 1) % N, "R8", "cyclic service order", served[t+1], (served[t] + 1) % N);
        for (int t = 0; t + N <= 8; t++) begin
            logic [N-1:0] seen = '0;
            for (int k = 0; k < N; k++) seen[served[t+k]] = 1'b1;
            check(seen == '1, "R8", "every input served in N slots", int'(seen), 15);
        end

        // Sweep over pseudo-random request matrices
        x = 16'hACE1;
        for (int p = 0; p < 3000; p++) begin
            logic [N*N-1:0] r;
            x = x ^ (x << 7); x = x ^ (x >> 9); x = x ^ (x << 8);
            r = (p < 256) ? 16'(p * 257) : x;
            slot(r, cm, cf);
            check(cm == 3 && cf == 4, "R4", "done latency sweep", cm, 3);
            check(legal(vld_m, port_m) && legal(vld_f, port_f), "R2", "legal matching", int'(port_m), -1);
            check(requested(r, vld_m, port_m) && requested(r, vld_f, port_f), "R3", "matches requested", int'(r), -1);
            check(maximal(r, vld_f, port_f), "R6", "maximal with N iterations", int'(vld_f), -1);
            check((r == '0) || (vld_m != '0), "R9", "progress on non-zero request", int'(vld_m), -1);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule